// File: doc/BRIEF.md
# Grouped-Instruction Sub-PC Sequencer

This block keeps a two-level program counter for a prefixed instruction group that runs as a small sub-program. When a group is entered, the main PC stays fixed on the address of the group's first byte. A sub-PC counts byte offsets from that start and steps through the opcodes inside the group as the decoder reports each opcode's length. When the sub-PC runs past the group length given at entry, the main PC moves forward by that length. At the same point the sub-PC returns to zero and the group-scoped register and predicate tags are cleared. The vector-length value stays as it was.

Each privilege level (user, supervisor, machine) has its own sub-PC save register, which works like an exception PC. A trap writes the current sub-PC into the register of the level that takes the trap, and the matching return reloads it. Branches inside a group carry a target offset relative to the group start. A target outside the group raises a one-cycle violation flag and leaves the sub-PC unchanged. A build without group support reports an illegal instruction for every group entry.

Top module: `subpc_seq`

## Requirements
- R1: While a group is active, main_pc stays constant until the group ends. Outside a group, op_valid advances main_pc by op_len.
- R2: On group entry the sub-PC is 0. Each op_valid inside the group adds op_len to it, and the sub-PC always stays below the group length.
- R3: When sub-PC plus op_len is greater than or equal to the group length, the group ends. main_pc then advances by the group length, the sub-PC returns to 0 and grp_active falls.
- R4: An in-group branch whose target is less than the group length loads the target into the sub-PC.
- R5: An in-group branch whose target is greater than or equal to the group length raises br_violation for exactly the following cycle and leaves the sub-PC unchanged. A branch outside a group has no effect.
- R6: trap_valid copies the sub-PC into the save register chosen by trap_lvl (0 = user, 1 = supervisor, 3 = machine). It deactivates the group and blocks op_valid until a return. Priority is trap, then return, then branch, then op, then group entry.
- R7: xret_valid reloads the sub-PC and the group-active state from the save register chosen by xret_lvl and leaves main_pc unchanged.
- R8: At group end, rtag_cur and ptag_cur become 0 and vl_cur keeps its value.
- R9: grp_start loads rtag_cur, ptag_cur and vl_cur. It is ignored when grp_len is 0, when a group is active, or after an unreturned trap.
- R10: With SUPPORT_GROUP = 0, grp_start raises illegal_insn for one cycle and never starts a group. With support present, illegal_insn stays 0.
- R11: After reset, main_pc equals RESET_PC and every other output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_start | input | 1 | Group prefix decoded |
| grp_len | input | SPC_W | Group length in bytes |
| grp_rtag | input | TAG_W | Register-tag context for the group |
| grp_ptag | input | TAG_W | Predicate-tag context for the group |
| grp_vl | input | VL_W | Vector length set by the group |
| op_valid | input | 1 | An opcode has retired |
| op_len | input | SPC_W | Byte length of that opcode |
| br_valid | input | 1 | Taken branch |
| br_tgt | input | SPC_W | Branch target offset from the group start |
| trap_valid | input | 1 | Trap entry |
| trap_lvl | input | 2 | Level taking the trap |
| xret_valid | input | 1 | Trap return |
| xret_lvl | input | 2 | Level returning |
| main_pc | output | PC_W | Main program counter |
| sub_pc | output | SPC_W | Offset inside the group |
| grp_active | output | 1 | Group in progress |
| br_violation | output | 1 | Out-of-group branch pulse |
| illegal_insn | output | 1 | Unsupported group pulse |
| sav_u | output | SPC_W | User save register |
| sav_s | output | SPC_W | Supervisor save register |
| sav_m | output | SPC_W | Machine save register |
| rtag_cur | output | TAG_W | Live register-tag context |
| ptag_cur | output | TAG_W | Live predicate-tag context |
| vl_cur | output | VL_W | Live vector length |

## Verification
All outputs are registered, so every result appears one clock after the edge that samples its stimulus. This includes the one-cycle br_violation and illegal_insn pulses, the save registers and the tag clear at group end. The bench changes inputs between edges and samples 5 ns after the next rising edge, which is one cycle after the stimulus. To prove that a pulse lasts only one cycle, the bench checks it again one cycle later. Save registers and tag state are read at the ports after the sequence that could have changed them.

// File: rtl/subpc_pkg.sv
package subpc_pkg;

   typedef enum logic [1:0] {
      PRIV_U    = 2'd0,
      PRIV_S    = 2'd1,
      PRIV_RSVD = 2'd2,
      PRIV_M    = 2'd3
   } priv_e;

   localparam int NUM_LVL = 3;

   // bank slot index -> privilege encoding
   function automatic logic [1:0] lvl_code(input int idx);
      case (idx)
         0:       lvl_code = PRIV_U;
         1:       lvl_code = PRIV_S;
         default: lvl_code = PRIV_M;
      endcase
   endfunction

endpackage

// File: rtl/subpc_br_chk.sv
module subpc_br_chk #(
   parameter int SPC_W = 8
) (
   input  logic [SPC_W-1:0] tgt,
   input  logic [SPC_W-1:0] len,
   output logic             in_range
);
   // targets are offsets from the group start; legal range is [0, len)
   assign in_range = (tgt < len);
endmodule

// File: rtl/subpc_trap_bank.sv
module subpc_trap_bank
   import subpc_pkg::*;
#(
   parameter int SPC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trap_valid,
   input  logic [1:0]       trap_lvl,
   input  logic [SPC_W-1:0] cur_spc,
   input  logic             cur_act,
   input  logic [1:0]       ret_lvl,
   output logic [SPC_W-1:0] ret_spc,
   output logic             ret_act,
   output logic [SPC_W-1:0] sav_u,
   output logic [SPC_W-1:0] sav_s,
   output logic [SPC_W-1:0] sav_m
);
   logic [NUM_LVL-1:0][SPC_W-1:0] spc_all;
   logic [NUM_LVL-1:0]            act_all;

   for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
      localparam logic [1:0] CODE = lvl_code(g);
      logic [SPC_W-1:0] spc_q;
      logic             act_q;
      logic             hit;

      assign hit = trap_valid && (trap_lvl == CODE);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            spc_q <= '0;
            act_q <= 1'b0;
         end else if (hit) begin
            spc_q <= cur_spc;
            act_q <= cur_act;
         end
      end

      assign spc_all[g] = spc_q;
      assign act_all[g] = act_q;

      // R6: the level taking the trap captures the running sub-PC
      a_r6_trap_save: assert property (@(posedge clk) disable iff (!rst_n)
         (trap_valid && trap_lvl == CODE) |=> (spc_all[g] == $past(cur_spc)));
   end

   always_comb begin
      ret_spc = '0;
      ret_act = 1'b0;
      for (int i = 0; i < NUM_LVL; i++) begin
         if (ret_lvl == lvl_code(i)) begin
            ret_spc = spc_all[i];
            ret_act = act_all[i];
         end
      end
   end

   assign sav_u = spc_all[0];
   assign sav_s = spc_all[1];
   assign sav_m = spc_all[2];
endmodule

// File: rtl/subpc_tag_ctx.sv
module subpc_tag_ctx #(
   parameter int TAG_W = 16,
   parameter int VL_W  = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             clr,
   input  logic [TAG_W-1:0] rtag_in,
   input  logic [TAG_W-1:0] ptag_in,
   input  logic [VL_W-1:0]  vl_in,
   output logic [TAG_W-1:0] rtag_q,
   output logic [TAG_W-1:0] ptag_q,
   output logic [VL_W-1:0]  vl_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rtag_q <= '0;
         ptag_q <= '0;
         vl_q   <= '0;
      end else if (clr) begin
         rtag_q <= '0;
         ptag_q <= '0;
      end else if (load) begin
         rtag_q <= rtag_in;
         ptag_q <= ptag_in;
         vl_q   <= vl_in;
      end
   end

   // R8: group-scoped tags vanish at group end, vector length persists
   a_r8_tags_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (rtag_q == '0 && ptag_q == '0));
   a_r8_vl_kept: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> $stable(vl_q));
endmodule

// File: rtl/subpc_core.sv
module subpc_core #(
   parameter int              PC_W          = 32,
   parameter int              SPC_W         = 8,
   parameter logic [PC_W-1:0] RESET_PC      = '0,
   parameter bit              SUPPORT_GROUP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             grp_start,
   input  logic [SPC_W-1:0] grp_len,
   input  logic             op_valid,
   input  logic [SPC_W-1:0] op_len,
   input  logic             br_valid,
   input  logic [SPC_W-1:0] br_tgt,
   input  logic             br_ok,
   input  logic             trap_valid,
   input  logic             xret_valid,
   input  logic [SPC_W-1:0] ret_spc,
   input  logic             ret_act,
   output logic [PC_W-1:0]  main_pc_q,
   output logic [SPC_W-1:0] sub_pc_q,
   output logic [SPC_W-1:0] len_q,
   output logic             active_q,
   output logic             viol_q,
   output logic             illegal_q,
   output logic             start_ok,
   output logic             end_now
);
   localparam int SUM_W = SPC_W + 1;

   logic             trapped_q;
   logic [SUM_W-1:0] spc_sum;
   logic             illegal_d;
   logic             quiet;

   assign spc_sum = {1'b0, sub_pc_q} + {1'b0, op_len};
   assign quiet   = !trap_valid && !xret_valid;

   assign end_now = quiet && active_q && !br_valid && op_valid
                    && (spc_sum >= {1'b0, len_q});

   if (SUPPORT_GROUP) begin : g_grp
      assign start_ok  = quiet && grp_start && !op_valid && !active_q
                         && !trapped_q && (grp_len != '0);
      assign illegal_d = 1'b0;
   end else begin : g_nogrp
      assign start_ok  = 1'b0;
      assign illegal_d = grp_start;

      // R10: unsupported build flags every group prefix and never enters one
      a_r10_illegal: assert property (@(posedge clk) disable iff (!rst_n)
         grp_start |=> illegal_q);
      a_r10_no_group: assert property (@(posedge clk) disable iff (!rst_n)
         !active_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         main_pc_q <= RESET_PC;
         sub_pc_q  <= '0;
         len_q     <= '0;
         active_q  <= 1'b0;
         trapped_q <= 1'b0;
         viol_q    <= 1'b0;
         illegal_q <= 1'b0;
      end else begin
         viol_q    <= 1'b0;
         illegal_q <= illegal_d;
         if (trap_valid) begin
            trapped_q <= 1'b1;
            active_q  <= 1'b0;
         end else if (xret_valid) begin
            trapped_q <= 1'b0;
            active_q  <= ret_act;
            sub_pc_q  <= ret_spc;
         end else if (br_valid && active_q) begin
            if (br_ok) sub_pc_q <= br_tgt;
            else       viol_q   <= 1'b1;
         end else if (op_valid && !trapped_q) begin
            if (active_q) begin
               if (end_now) begin
                  main_pc_q <= main_pc_q + PC_W'(len_q);
                  sub_pc_q  <= '0;
                  active_q  <= 1'b0;
               end else begin
                  sub_pc_q  <= spc_sum[SPC_W-1:0];
               end
            end else begin
               main_pc_q <= main_pc_q + PC_W'(op_len);
            end
         end else if (start_ok) begin
            active_q <= 1'b1;
            len_q    <= grp_len;
            sub_pc_q <= '0;
         end
      end
   end

   // R1: main PC is pinned to the group start until the group finishes
   a_r1_main_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && !end_now) |=> $stable(main_pc_q));
   // R2: sub-PC never leaves the group while active
   a_r2_spc_bound: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |-> (sub_pc_q < len_q));
   // R3: group end returns to normal flow at offset zero
   a_r3_end_resets: assert property (@(posedge clk) disable iff (!rst_n)
      end_now |=> (!active_q && sub_pc_q == '0));
   // R5: a flagged branch leaves the sub-PC where it was
   a_r5_viol_hold: assert property (@(posedge clk) disable iff (!rst_n)
      viol_q |-> $stable(sub_pc_q));
endmodule

// File: rtl/subpc_seq.sv
module subpc_seq
   import subpc_pkg::*;
#(
   parameter int              PC_W          = 32,
   parameter int              SPC_W         = 8,
   parameter int              TAG_W         = 16,
   parameter int              VL_W          = 6,
   parameter logic [PC_W-1:0] RESET_PC      = 32'h0000_0100,
   parameter bit              SUPPORT_GROUP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             grp_start,
   input  logic [SPC_W-1:0] grp_len,
   input  logic [TAG_W-1:0] grp_rtag,
   input  logic [TAG_W-1:0] grp_ptag,
   input  logic [VL_W-1:0]  grp_vl,
   input  logic             op_valid,
   input  logic [SPC_W-1:0] op_len,
   input  logic             br_valid,
   input  logic [SPC_W-1:0] br_tgt,
   input  logic             trap_valid,
   input  logic [1:0]       trap_lvl,
   input  logic             xret_valid,
   input  logic [1:0]       xret_lvl,
   output logic [PC_W-1:0]  main_pc,
   output logic [SPC_W-1:0] sub_pc,
   output logic             grp_active,
   output logic             br_violation,
   output logic             illegal_insn,
   output logic [SPC_W-1:0] sav_u,
   output logic [SPC_W-1:0] sav_s,
   output logic [SPC_W-1:0] sav_m,
   output logic [TAG_W-1:0] rtag_cur,
   output logic [TAG_W-1:0] ptag_cur,
   output logic [VL_W-1:0]  vl_cur
);
   if (SPC_W < 2 || SPC_W >= PC_W) begin : g_bad_spc
      $error("subpc_seq: SPC_W must lie in [2, PC_W)");
   end
   if (TAG_W < 1 || VL_W < 1) begin : g_bad_ctx
      $error("subpc_seq: TAG_W and VL_W must be positive");
   end

   logic [SPC_W-1:0] len_q;
   logic [SPC_W-1:0] ret_spc;
   logic             ret_act;
   logic             br_ok;
   logic             start_ok;
   logic             end_now;

   subpc_br_chk #(.SPC_W(SPC_W)) u_br_chk (
      .tgt      (br_tgt),
      .len      (len_q),
      .in_range (br_ok)
   );

   subpc_core #(
      .PC_W          (PC_W),
      .SPC_W         (SPC_W),
      .RESET_PC      (RESET_PC),
      .SUPPORT_GROUP (SUPPORT_GROUP)
   ) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .grp_start  (grp_start),
      .grp_len    (grp_len),
      .op_valid   (op_valid),
      .op_len     (op_len),
      .br_valid   (br_valid),
      .br_tgt     (br_tgt),
      .br_ok      (br_ok),
      .trap_valid (trap_valid),
      .xret_valid (xret_valid),
      .ret_spc    (ret_spc),
      .ret_act    (ret_act),
      .main_pc_q  (main_pc),
      .sub_pc_q   (sub_pc),
      .len_q      (len_q),
      .active_q   (grp_active),
      .viol_q     (br_violation),
      .illegal_q  (illegal_insn),
      .start_ok   (start_ok),
      .end_now    (end_now)
   );

   subpc_trap_bank #(.SPC_W(SPC_W)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .trap_valid (trap_valid),
      .trap_lvl   (trap_lvl),
      .cur_spc    (sub_pc),
      .cur_act    (grp_active),
      .ret_lvl    (xret_lvl),
      .ret_spc    (ret_spc),
      .ret_act    (ret_act),
      .sav_u      (sav_u),
      .sav_s      (sav_s),
      .sav_m      (sav_m)
   );

   subpc_tag_ctx #(.TAG_W(TAG_W), .VL_W(VL_W)) u_tags (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (start_ok),
      .clr     (end_now),
      .rtag_in (grp_rtag),
      .ptag_in (grp_ptag),
      .vl_in   (grp_vl),
      .rtag_q  (rtag_cur),
      .ptag_q  (ptag_cur),
      .vl_q    (vl_cur)
   );

   // R7: a return never moves the main PC
   a_r7_ret_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      xret_valid |=> $stable(main_pc));
endmodule

// File: tb/subpc_seq_bench.sv
module subpc_seq_bench;
   localparam int PC_W  = 32;
   localparam int SPC_W = 8;
   localparam int TAG_W = 16;
   localparam int VL_W  = 6;

   typedef struct packed {
      logic        st;
      logic [7:0]  len;
      logic        op;
      logic [7:0]  olen;
      logic        br;
      logic [7:0]  tgt;
      logic        trap;
      logic        xret;
      logic [1:0]  lvl;
      logic [31:0] mpc;
      logic [7:0]  spc;
      logic        act;
      logic        viol;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 8'd0,  1'b1, 8'd4, 1'b0, 8'd0,   1'b0, 1'b0, 2'd0, 32'd260, 8'd0,  1'b0, 1'b0}, // R1 outside
      '{1'b1, 8'd12, 1'b0, 8'd0, 1'b0, 8'd0,   1'b0, 1'b0, 2'd0, 32'd260, 8'd0,  1'b1, 1'b0}, // R9 enter
      '{1'b0, 8'd0,  1'b1, 8'd4, 1'b0, 8'd0,   1'b0, 1'b0, 2'd0, 32'd260, 8'd4,  1'b1, 1'b0}, // R2
      '{1'b0, 8'd0,  1'b1, 8'd2, 1'b0, 8'd0,   1'b0, 1'b0, 2'd0, 32'd260, 8'd6,  1'b1, 1'b0}, // R2
      '{1'b0, 8'd0,  1'b0, 8'd0, 1'b1, 8'd2,   1'b0, 1'b0, 2'd0, 32'd260, 8'd2,  1'b1, 1'b0}, // R4
      '{1'b0, 8'd0,  1'b0, 8'd0, 1'b1, 8'd12,  1'b0, 1'b0, 2'd0, 32'd260, 8'd2,  1'b1, 1'b1}, // R5 edge
      '{1'b0, 8'd0,  1'b0, 8'd0, 1'b1, 8'd200, 1'b0, 1'b0, 2'd0, 32'd260, 8'd2,  1'b1, 1'b1}, // R5 far
      '{1'b0, 8'd0,  1'b1, 8'd4, 1'b0, 8'd0,   1'b0, 1'b0, 2'd0, 32'd260, 8'd6,  1'b1, 1'b0}, // R2
      '{1'b0, 8'd0,  1'b0, 8'd0, 1'b0, 8'd0,   1'b1, 1'b0, 2'd1, 32'd260, 8'd6,  1'b0, 1'b0}, // R6
      '{1'b0, 8'd0,  1'b1, 8'd4, 1'b0, 8'd0,   1'b0, 1'b0, 2'd0, 32'd260, 8'd6,  1'b0, 1'b0}, // R6 blocked
      '{1'b0, 8'd0,  1'b0, 8'd0, 1'b0, 8'd0,   1'b0, 1'b1, 2'd1, 32'd260, 8'd6,  1'b1, 1'b0}, // R7
      '{1'b0, 8'd0,  1'b1, 8'd4, 1'b0, 8'd0,   1'b0, 1'b0, 2'd0, 32'd260, 8'd10, 1'b1, 1'b0}, // R2
      '{1'b0, 8'd0,  1'b1, 8'd4, 1'b0, 8'd0,   1'b0, 1'b0, 2'd0, 32'd272, 8'd0,  1'b0, 1'b0}, // R3
      '{1'b0, 8'd0,  1'b1, 8'd2, 1'b0, 8'd0,   1'b0, 1'b0, 2'd0, 32'd274, 8'd0,  1'b0, 1'b0}, // R1
      '{1'b0, 8'd0,  1'b0, 8'd0, 1'b1, 8'd50,  1'b0, 1'b0, 2'd0, 32'd274, 8'd0,  1'b0, 1'b0}  // R5 no group
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             grp_start = 1'b0;
   logic [SPC_W-1:0] grp_len = '0;
   logic [TAG_W-1:0] grp_rtag = 16'hA5C3;
   logic [TAG_W-1:0] grp_ptag = 16'h3C0F;
   logic [VL_W-1:0]  grp_vl = 6'd9;
   logic             op_valid = 1'b0;
   logic [SPC_W-1:0] op_len = '0;
   logic             br_valid = 1'b0;
   logic [SPC_W-1:0] br_tgt = '0;
   logic             trap_valid = 1'b0;
   logic [1:0]       trap_lvl = '0;
   logic             xret_valid = 1'b0;
   logic [1:0]       xret_lvl = '0;
   logic             ng_start = 1'b0;

   logic [PC_W-1:0]  main_pc;
   logic [SPC_W-1:0] sub_pc, sav_u, sav_s, sav_m;
   logic             grp_active, br_violation, illegal_insn;
   logic [TAG_W-1:0] rtag_cur, ptag_cur;
   logic [VL_W-1:0]  vl_cur;

   logic [PC_W-1:0]  ng_pc;
   logic [SPC_W-1:0] ng_spc, ng_su, ng_ss, ng_sm;
   logic             ng_act, ng_viol, ng_ill;
   logic [TAG_W-1:0] ng_rt, ng_pt;
   logic [VL_W-1:0]  ng_vl;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   subpc_seq u_subpc_seq (
      .clk, .rst_n, .grp_start, .grp_len, .grp_rtag, .grp_ptag, .grp_vl,
      .op_valid, .op_len, .br_valid, .br_tgt, .trap_valid, .trap_lvl,
      .xret_valid, .xret_lvl, .main_pc, .sub_pc, .grp_active, .br_violation,
      .illegal_insn, .sav_u, .sav_s, .sav_m, .rtag_cur, .ptag_cur, .vl_cur
   );

   subpc_seq #(.SUPPORT_GROUP(1'b0)) u_subpc_seq_nogrp (
      .clk, .rst_n, .grp_start(ng_start), .grp_len(8'd8), .grp_rtag, .grp_ptag,
      .grp_vl, .op_valid(1'b0), .op_len, .br_valid(1'b0), .br_tgt,
      .trap_valid(1'b0), .trap_lvl, .xret_valid(1'b0), .xret_lvl,
      .main_pc(ng_pc), .sub_pc(ng_spc), .grp_active(ng_act),
      .br_violation(ng_viol), .illegal_insn(ng_ill), .sav_u(ng_su),
      .sav_s(ng_ss), .sav_m(ng_sm), .rtag_cur(ng_rt), .ptag_cur(ng_pt),
      .vl_cur(ng_vl)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   task automatic idle();
      grp_start = 1'b0; grp_len = '0; op_valid = 1'b0; op_len = '0;
      br_valid = 1'b0; br_tgt = '0; trap_valid = 1'b0; xret_valid = 1'b0;
      trap_lvl = '0; xret_lvl = '0; ng_start = 1'b0;
   endtask

   // one edge, then sample 5 ns after it
   task automatic cyc();
      @(posedge clk);
      #5;
      idle();
   endtask

   task automatic do_op(input logic [7:0] n);
      op_valid = 1'b1; op_len = n; cyc();
   endtask

   task automatic do_start(input logic [7:0] n);
      grp_start = 1'b1; grp_len = n; cyc();
   endtask

   initial begin
      #(20 * 200000);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      idle();
      repeat (3) @(posedge clk);
      #5 rst_n = 1'b1;
      // R11 reset state
      chk("R11 main_pc", main_pc, 32'h100);
      chk("R11 sub_pc", 32'(sub_pc), 32'd0);
      chk("R11 active", 32'(grp_active), 32'd0);
      chk("R11 viol", 32'(br_violation), 32'd0);
      chk("R11 sav", 32'({sav_u, sav_s, sav_m}), 32'd0);
      chk("R11 tags", 32'({rtag_cur, ptag_cur} != 0), 32'd0);
      chk("R11 vl", 32'(vl_cur), 32'd0);
      chk("R11 illegal", 32'(illegal_insn), 32'd0);

      for (int i = 0; i < NV; i++) begin
         grp_start = VECS[i].st;   grp_len = VECS[i].len;
         op_valid = VECS[i].op;    op_len = VECS[i].olen;
         br_valid = VECS[i].br;    br_tgt = VECS[i].tgt;
         trap_valid = VECS[i].trap; trap_lvl = VECS[i].lvl;
         xret_valid = VECS[i].xret; xret_lvl = VECS[i].lvl;
         cyc();
         chk($sformatf("R1 R3 main_pc vec %0d", i), main_pc, VECS[i].mpc);
         chk($sformatf("R2 R4 sub_pc vec %0d", i), 32'(sub_pc), 32'(VECS[i].spc));
         chk($sformatf("R6 R7 active vec %0d", i), 32'(grp_active), 32'(VECS[i].act));
         chk($sformatf("R5 viol vec %0d", i), 32'(br_violation), 32'(VECS[i].viol));
      end

      // R8 tags dropped at end, vl kept; R6 save registers per level
      chk("R8 rtag cleared", 32'(rtag_cur), 32'd0);
      chk("R8 ptag cleared", 32'(ptag_cur), 32'd0);
      chk("R8 vl kept", 32'(vl_cur), 32'd9);
      chk("R6 sav_s", 32'(sav_s), 32'd6);
      chk("R6 sav_u untouched", 32'(sav_u), 32'd0);
      chk("R6 sav_m untouched", 32'(sav_m), 32'd0);

      // R9 load on entry, then a second entry is ignored (length stays 8)
      grp_vl = 6'd5;
      do_start(8'd8);
      chk("R9 rtag loaded", 32'(rtag_cur), 32'hA5C3);
      chk("R9 ptag loaded", 32'(ptag_cur), 32'h3C0F);
      chk("R9 vl loaded", 32'(vl_cur), 32'd5);
      grp_vl = 6'd30;
      do_start(8'd20);
      chk("R9 restart ignored vl", 32'(vl_cur), 32'd5);
      do_op(8'd6);
      chk("R2 sub_pc 6", 32'(sub_pc), 32'd6);
      do_op(8'd2);
      chk("R3 exact end main_pc", main_pc, 32'd282);
      chk("R3 exact end active", 32'(grp_active), 32'd0);

      // R9 zero length ignored
      do_start(8'd0);
      chk("R9 zero len", 32'(grp_active), 32'd0);

      // R6/R7 machine level round trip
      do_start(8'd8);
      do_op(8'd2);
      trap_valid = 1'b1; trap_lvl = 2'd3; cyc();
      chk("R6 sav_m", 32'(sav_m), 32'd2);
      chk("R6 trap inactive", 32'(grp_active), 32'd0);
      xret_valid = 1'b1; xret_lvl = 2'd3; cyc();
      chk("R7 restore sub_pc", 32'(sub_pc), 32'd2);
      chk("R7 restore active", 32'(grp_active), 32'd1);
      chk("R7 main_pc held", main_pc, 32'd282);
      do_op(8'd6);
      chk("R3 end after return", main_pc, 32'd290);

      // R10 unsupported build
      ng_start = 1'b1; cyc();
      chk("R10 illegal pulse", 32'(ng_ill), 32'd1);
      chk("R10 no group", 32'(ng_act), 32'd0);
      cyc();
      chk("R10 pulse one cycle", 32'(ng_ill), 32'd0);
      chk("R10 supported no illegal", 32'(illegal_insn), 32'd0);

      report();
   end
endmodule